// File: doc/BRIEF.md
# Byte Peripheral Command Port

This block connects a simple single-cycle processor bus to one byte-wide peripheral. Software talks to it through three registers at one base address: a byte buffer, a combined command/status register and a control register. Writing an opcode to the command register starts one of four operations. Two of them send the buffer byte out: one as a configuration item and one as plain data. One fetches a byte in, and one samples the peripheral's fault line. Each transfer with the peripheral uses a valid/ready handshake in the relevant direction.

Completion is shown in the status register, so software can poll for it. If the enable bit in the control register is set, completion also raises an interrupt line. That line stays up until software reads the buffer or issues the next command. Every byte crossing the link carries an even-parity bit. A received byte with a bad parity bit, or a peripheral fault seen when an operation finishes, is flagged in status. A command written while an operation is still running is dropped and leaves a sticky overrun flag.

Top module: `byte_io_port`

## Requirements
- R1: The block responds only when the upper address bits (all but the two lowest) equal those of `BASE_ADDR`. Any other write changes nothing, and any other read returns 0 on `bus_rdata`.
- R2: The low two address bits select the register: 0 is the data buffer, 1 is command (write) or status (read), 2 is control with bit 0 as interrupt enable, and 3 reads as 0. Read data appears on `bus_rdata` in the cycle after `bus_rd`. It is 0 in cycles that follow no matching read.
- R3: Command opcode 3 (write data, in `bus_wdata[1:0]`) asserts `per_tx_valid` with the buffer byte on `per_tx_data` and `per_tx_cfg`=0. All three are held unchanged until `per_tx_ready` is seen. `per_tx_par` is the even-parity bit, so that data plus parity holds an even number of ones.
- R4: Command opcode 0 (configure) runs the same send with `per_tx_cfg`=1.
- R5: Command opcode 2 (fetch) asserts `per_rx_ready` until `per_rx_valid` is seen. The received byte is then stored in the data buffer.
- R6: Command opcode 1 (test) keeps busy for exactly one cycle, then completes. It records `per_fault` from that completion cycle in the device-error bit.
- R7: Status bit 0 (busy) is set from the cycle after a command is accepted until the handshake completes. Status bit 1 (done) is set after completion. Done clears when the data buffer is read or a new command is accepted.
- R8: `irq` equals done AND interrupt enable. With enable 0 (polled use), `irq` never rises.
- R9: Status bit 2 is set when `per_fault` is high at completion. Status bit 3 is set when a received byte and its parity bit hold an odd number of ones. Both clear when the next command is accepted.
- R10: A command written while busy is ignored and sets status bit 4 (overrun). This bit stays set until a status read, which returns it as 1 and then clears it.
- R11: Writes to the data buffer while busy are ignored.
- R12: After reset, status and control read 0, and `irq`, `per_tx_valid` and `per_rx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Registered bus read data |
| irq | output | 1 | Completion interrupt request |
| per_tx_valid | output | 1 | Outbound item valid |
| per_tx_ready | input | 1 | Peripheral accepts outbound item |
| per_tx_data | output | DATA_W | Outbound byte |
| per_tx_par | output | 1 | Outbound even-parity bit |
| per_tx_cfg | output | 1 | Outbound item is configuration (1) or data (0) |
| per_rx_valid | input | 1 | Inbound item valid |
| per_rx_ready | output | 1 | Block wants an inbound item |
| per_rx_data | input | DATA_W | Inbound byte |
| per_rx_par | input | 1 | Inbound parity bit |
| per_fault | input | 1 | Peripheral fault indication |

## Verification
The hardest state to reach is overrun. It needs a second command to land while the first is still stalled in its handshake. The peripheral model reaches it by holding `per_tx_ready` low on purpose. While the send is held open, the bench writes a new buffer byte and a second command. It then checks that the outbound byte and its kind are unchanged, and that two back-to-back status reads return overrun set and then cleared. Parity and fault errors are reached by driving a deliberately wrong parity bit or a raised fault line in the exact handshake cycle.

// File: rtl/bio_pkg.sv
package bio_pkg;

    typedef enum logic [1:0] {
        OP_CFG   = 2'b00,
        OP_TEST  = 2'b01,
        OP_FETCH = 2'b10,
        OP_SEND  = 2'b11
    } bio_op_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'b00,
        XS_TX   = 2'b01,
        XS_RX   = 2'b10,
        XS_TST  = 2'b11
    } bio_xstate_e;

    typedef enum logic [1:0] {
        RS_BUF  = 2'b00,
        RS_CMD  = 2'b01,
        RS_CTL  = 2'b10,
        RS_NONE = 2'b11
    } bio_rsel_e;

    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 1;
    localparam int SB_DERR = 2;
    localparam int SB_PERR = 3;
    localparam int SB_OVR  = 4;

endpackage

// File: rtl/bio_addr_dec.sv
module bio_addr_dec
    import bio_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output bio_rsel_e         sel
);
    localparam int SEL_W = 2;

    always_comb begin
        hit = (addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
        sel = bio_rsel_e'(addr[SEL_W-1:0]);
    end
endmodule

// File: rtl/bio_parity.sv
module bio_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         even_bit
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign acc[i+1] = acc[i] ^ data[i];
    end
    assign even_bit = acc[W];
endmodule

// File: rtl/bio_xfer_fsm.sv
module bio_xfer_fsm
    import bio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  bio_op_e           op,
    input  logic [DATA_W-1:0] out_byte,
    input  logic              dev_fault,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_par,
    output logic              tx_cfg,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par,
    output logic              busy,
    output logic              fin,
    output logic              fin_derr,
    output logic              fin_perr,
    output logic              fin_capture
);
    typedef struct packed {
        bio_xstate_e st;
        logic        cfg;
    } xfer_regs_t;

    xfer_regs_t r_q, r_d;
    logic rx_calc;

    bio_parity #(.W(DATA_W)) u_tx_par (.data(out_byte), .even_bit(tx_par));
    bio_parity #(.W(DATA_W)) u_rx_par (.data(rx_data),  .even_bit(rx_calc));

    always_comb begin
        r_d         = r_q;
        fin         = 1'b0;
        fin_capture = 1'b0;
        case (r_q.st)
            XS_IDLE: begin
                if (start) begin
                    case (op)
                        OP_CFG:   begin r_d.st = XS_TX; r_d.cfg = 1'b1; end
                        OP_SEND:  begin r_d.st = XS_TX; r_d.cfg = 1'b0; end
                        OP_FETCH: r_d.st = XS_RX;
                        default:  r_d.st = XS_TST;
                    endcase
                end
            end
            XS_TX: begin
                if (tx_ready) begin
                    r_d.st = XS_IDLE;
                    fin    = 1'b1;
                end
            end
            XS_RX: begin
                if (rx_valid) begin
                    r_d.st      = XS_IDLE;
                    fin         = 1'b1;
                    fin_capture = 1'b1;
                end
            end
            default: begin
                r_d.st = XS_IDLE;
                fin    = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: XS_IDLE, cfg: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != XS_IDLE);
    assign tx_valid = (r_q.st == XS_TX);
    assign rx_ready = (r_q.st == XS_RX);
    assign tx_data  = out_byte;
    assign tx_cfg   = r_q.cfg;
    assign fin_derr = fin & dev_fault;
    assign fin_perr = fin_capture & (rx_calc != rx_par);

    // R3: an offered item stays put until taken
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_cfg)));

    // R6: a test command is busy for exactly one cycle
    a_r6_test_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == OP_TEST) |=> (busy && fin) ##1 !busy);

    // R5: the inbound side is only open while fetching
    a_r5_rx_only_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != OP_FETCH) |=> !rx_ready);
endmodule

// File: rtl/byte_io_port.sv
module byte_io_port
    import bio_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              per_tx_valid,
    input  logic              per_tx_ready,
    output logic [DATA_W-1:0] per_tx_data,
    output logic              per_tx_par,
    output logic              per_tx_cfg,
    input  logic              per_rx_valid,
    output logic              per_rx_ready,
    input  logic [DATA_W-1:0] per_rx_data,
    input  logic              per_rx_par,
    input  logic              per_fault
);
    localparam int STAT_BITS = SB_OVR + 1;

    typedef struct packed {
        logic [DATA_W-1:0] buf_b;
        logic              ien;
        logic              done;
        logic              derr;
        logic              perr;
        logic              ovr;
        logic [DATA_W-1:0] rdata;
    } port_regs_t;

    port_regs_t r_q, r_d;

    logic      hit;
    bio_rsel_e sel;
    logic      busy, fin, fin_derr, fin_perr, fin_capture;
    logic      start;
    logic      wr_hit, rd_hit;
    logic [STAT_BITS-1:0] status;

    bio_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .hit(hit), .sel(sel)
    );

    bio_xfer_fsm #(.DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .start(start), .op(bio_op_e'(bus_wdata[1:0])), .out_byte(r_q.buf_b),
        .dev_fault(per_fault),
        .tx_valid(per_tx_valid), .tx_ready(per_tx_ready), .tx_data(per_tx_data),
        .tx_par(per_tx_par), .tx_cfg(per_tx_cfg),
        .rx_valid(per_rx_valid), .rx_ready(per_rx_ready), .rx_data(per_rx_data),
        .rx_par(per_rx_par),
        .busy(busy), .fin(fin), .fin_derr(fin_derr), .fin_perr(fin_perr),
        .fin_capture(fin_capture)
    );

    always_comb begin
        wr_hit = bus_wr & hit;
        rd_hit = bus_rd & hit;
        start  = wr_hit && (sel == RS_CMD) && !busy;
        status = '0;
        status[SB_BUSY] = busy;
        status[SB_DONE] = r_q.done;
        status[SB_DERR] = r_q.derr;
        status[SB_PERR] = r_q.perr;
        status[SB_OVR]  = r_q.ovr;
    end

    always_comb begin
        r_d       = r_q;
        r_d.rdata = '0;
        if (rd_hit) begin
            case (sel)
                RS_BUF:  r_d.rdata = r_q.buf_b;
                RS_CMD:  r_d.rdata = DATA_W'(status);
                RS_CTL:  r_d.rdata = DATA_W'(r_q.ien);
                default: r_d.rdata = '0;
            endcase
            if (sel == RS_CMD) r_d.ovr  = 1'b0;
            if (sel == RS_BUF) r_d.done = 1'b0;
        end
        if (wr_hit) begin
            case (sel)
                RS_BUF: if (!busy) r_d.buf_b = bus_wdata;
                RS_CMD: begin
                    if (busy) begin
                        r_d.ovr = 1'b1;
                    end else begin
                        r_d.done = 1'b0;
                        r_d.derr = 1'b0;
                        r_d.perr = 1'b0;
                    end
                end
                RS_CTL: r_d.ien = bus_wdata[0];
                default: ;
            endcase
        end
        if (fin) begin
            r_d.done = 1'b1;
            r_d.derr = fin_derr;
            r_d.perr = fin_perr;
            if (fin_capture) r_d.buf_b = per_rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;
    assign irq       = r_q.done & r_q.ien;

    // R8: polled use never interrupts
    a_r8_no_irq_polled: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ien |-> !irq);

    // R10: command while busy marks overrun
    a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && sel == RS_CMD && busy) |=> r_q.ovr);

    // R7: done and busy never coexist
    a_r7_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.done && busy));

    // R11: buffer is frozen while an operation is in flight without capture
    a_r11_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin_capture) |=> $stable(r_q.buf_b));

    // R1: no matching read leaves read data at zero
    a_r1_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && hit) |=> (bus_rdata == '0));
endmodule

// File: tb/byte_io_port_tb_top.sv
module byte_io_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_BUF   = 8'h40;
    localparam logic [7:0] A_CMD   = 8'h41;
    localparam logic [7:0] A_CTL   = 8'h42;
    localparam logic [7:0] A_HOLE  = 8'h43;
    localparam logic [7:0] A_OTHER = 8'h80;

    // vector: op[20:19] byte[18:11] flip[10] fault[9] ien[8] exp_stat[7:0]
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {2'd3, 8'hA5, 1'b0, 1'b0, 1'b1, 8'h02},
        {2'd0, 8'h3C, 1'b0, 1'b1, 1'b0, 8'h06},
        {2'd2, 8'h5A, 1'b0, 1'b0, 1'b1, 8'h02},
        {2'd2, 8'h81, 1'b1, 1'b0, 1'b0, 8'h0A},
        {2'd2, 8'hFF, 1'b1, 1'b1, 1'b1, 8'h0E},
        {2'd1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02},
        {2'd1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h06},
        {2'd3, 8'h07, 1'b0, 1'b0, 1'b0, 8'h02}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       per_tx_valid, per_tx_par, per_tx_cfg, per_rx_ready;
    logic       per_tx_ready = 1'b0;
    logic [7:0] per_tx_data;
    logic       per_rx_valid = 1'b0;
    logic [7:0] per_rx_data = '0;
    logic       per_rx_par = 1'b0;
    logic       per_fault = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_io_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .per_tx_valid(per_tx_valid), .per_tx_ready(per_tx_ready), .per_tx_data(per_tx_data),
        .per_tx_par(per_tx_par), .per_tx_cfg(per_tx_cfg),
        .per_rx_valid(per_rx_valid), .per_rx_ready(per_rx_ready), .per_rx_data(per_rx_data),
        .per_rx_par(per_rx_par), .per_fault(per_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdr(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 irq", irq, 0);
        chk("R12 tx_valid", per_tx_valid, 0);
        chk("R12 rx_ready", per_rx_ready, 0);
        rdr(A_CMD, rd); chk("R12 status", rd, 8'h00);
        rdr(A_CTL, rd); chk("R12 control", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] byt, est;
            logic flip, flt, ien;
            {op, byt, flip, flt, ien, est} = VEC[i];
            wr(A_CTL, {7'd0, ien});
            if (op == 2'd3 || op == 2'd0) begin
                wr(A_BUF, byt);
                wr(A_CMD, {6'd0, op});
                chk("R3 tx_valid", per_tx_valid, 1);
                chk("R3 tx_data", per_tx_data, byt);
                chk("R3 tx_par even", per_tx_par, ^byt);
                chk("R4 tx_cfg kind", per_tx_cfg, (op == 2'd0));
                rdr(A_CMD, rd); chk("R7 busy while sending", rd, 8'h01);
                per_tx_ready = 1'b1; per_fault = flt;
                @(posedge clk); @(negedge clk);
                per_tx_ready = 1'b0; per_fault = 1'b0;
                chk("R3 tx_valid drops", per_tx_valid, 0);
                chk("R8 irq after send", irq, ien);
                rdr(A_CMD, rd); chk("R9 send status", rd, est);
                rdr(A_BUF, rd); chk("R2 buffer readback", rd, byt);
                chk("R7 irq cleared by data read", irq, 0);
            end else if (op == 2'd2) begin
                wr(A_CMD, 8'h02);
                chk("R5 rx_ready", per_rx_ready, 1);
                per_rx_valid = 1'b1; per_rx_data = byt;
                per_rx_par = (^byt) ^ flip; per_fault = flt;
                @(posedge clk); @(negedge clk);
                per_rx_valid = 1'b0; per_fault = 1'b0;
                chk("R5 rx_ready drops", per_rx_ready, 0);
                chk("R8 irq after fetch", irq, ien);
                rdr(A_CMD, rd); chk("R9 fetch status", rd, est);
                rdr(A_BUF, rd); chk("R5 fetched byte", rd, byt);
                chk("R7 irq cleared by data read", irq, 0);
            end else begin
                per_fault = flt;
                wr(A_CMD, 8'h01);
                rdr(A_CMD, rd); chk("R6 test busy one cycle", rd, 8'h01);
                per_fault = 1'b0;
                rdr(A_CMD, rd); chk("R6 test status", rd, est);
                chk("R8 irq after test", irq, ien);
            end
        end

        // R7: a new command clears done from the previous one
        wr(A_CTL, 8'h00);
        wr(A_CMD, 8'h01);
        rdr(A_CMD, rd); chk("R7 done cleared by new command", rd, 8'h01);
        rdr(A_CMD, rd); chk("R7 done after test", rd, 8'h02);

        // R10 / R11 overrun with a stalled send
        wr(A_BUF, 8'h11);
        wr(A_CMD, 8'h03);
        repeat (3) @(negedge clk);
        chk("R3 held while not ready", per_tx_valid, 1);
        wr(A_BUF, 8'h99);
        chk("R11 tx data unchanged", per_tx_data, 8'h11);
        wr(A_CMD, 8'h02);
        chk("R10 kind unchanged", per_tx_cfg, 0);
        chk("R10 no fetch started", per_rx_ready, 0);
        rdr(A_CMD, rd); chk("R10 overrun seen", rd, 8'h11);
        rdr(A_CMD, rd); chk("R10 overrun cleared by read", rd, 8'h01);
        per_tx_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        per_tx_ready = 1'b0;
        rdr(A_BUF, rd); chk("R11 buffer kept", rd, 8'h11);

        // R1 / R2 address decoding
        wr(A_OTHER, 8'h77);
        rdr(A_BUF, rd); chk("R1 foreign write ignored", rd, 8'h11);
        rdr(A_OTHER, rd); chk("R1 foreign read zero", rd, 8'h00);
        rdr(A_HOLE, rd); chk("R2 offset 3 reads zero", rd, 8'h00);
        wr(A_CTL, 8'hFF);
        rdr(A_CTL, rd); chk("R2 control readback", rd, 8'h01);
        @(negedge clk);
        chk("R2 rdata zero without read", bus_rdata, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule